// File: doc/BRIEF.md
# Looping Register Bank for a Six-Channel Converter Interface

This block is the register file behind the serial port of a six-channel sampling converter. It has eleven 24-bit registers. Six hold conversion results and are read-only. Five hold control settings and can be read and written. A shifter outside the block turns serial pins into strobes. It tells the bank when an access starts, including the starting address and whether the access reads or writes. During a read it asks for one byte at a time. During a write it hands over one byte at a time.

An internal address pointer moves on after every complete 24-bit register. The next address wraps inside a region picked by a 2-bit wrap field held in the status register. The region can be a small group, all registers of the same type, or the whole map. The pointer can also be told to stay on the same register. A host can therefore stream a set of registers for as long as it likes after sending one address.

Conversion results arrive together with a one-cycle ready pulse. They are copied into a snapshot that reads are served from. The snapshot is refreshed only between registers, so the three bytes of one result always come from the same sample.

Top module: `afe_regbank`

## Requirements
- R1: Addresses 0x00–0x05 read channel results 0–5. Addresses 0x06–0x0A read the five control registers. A read byte appears on `rd_byte` with `rd_valid` high for exactly the one cycle after the clock edge that accepted `byte_req`.
- R2: The bytes of a register come out most significant first. Byte 0 is bits [23:16], then [15:8], then [7:0]. Writes take their bytes in the same order.
- R3: After reset, `rd_valid` and `rd_byte` are zero. Control registers 0x06, 0x07, 0x08 and 0x0A are zero. Register 0x09 is 0x800000, which puts wrap field 2'b10 in bits [23:22].
- R4: With wrap field 2'b00 the pointer stays where it is, so every register read returns the same address again.
- R5: With wrap field 2'b01 the pointer cycles inside its group. The groups are {0x00,0x01}, {0x02,0x03}, {0x04,0x05}, {0x06,0x07,0x08} and {0x09,0x0A}.
- R6: With wrap field 2'b10 the pointer cycles 0x00→0x05→0x00 among results, or 0x06→0x0A→0x06 among controls.
- R7: With wrap field 2'b11 the pointer walks the whole map and wraps from 0x0A to 0x00.
- R8: A write to 0x00–0x05 changes no register, but the pointer still advances under the wrap rule.
- R9: A control register changes only when its third write byte arrives. If a new access starts after fewer bytes, that register is left unchanged.
- R10: Results are copied into the read snapshot when a read access starts. A sample that arrives after the first byte of a register has been sent is held back. It is applied at the next register boundary, so that register returns the old sample and the following one returns the new sample.
- R11: During a read, a sample that arrives while no byte of the current register has been sent is visible in that register.
- R12: `byte_req` has no effect outside a read access, and `wr_valid` has no effect outside a write access.
- R13: The wrap field is bits [23:22] of register 0x09. A new value written there governs every pointer advance after the write completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_start | input | 1 | Starts an access. Takes priority over byte strobes in the same cycle |
| acc_addr | input | 4 | Starting register address |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| byte_req | input | 1 | Requests the next read byte |
| wr_valid | input | 1 | Qualifies `wr_byte` during a write |
| wr_byte | input | 8 | Write data byte |
| smp_ready | input | 1 | One-cycle pulse: new results on `smp_data` |
| smp_data | input | 144 | Six 24-bit results. Channel n sits at bits [24n+23:24n] |
| rd_valid | output | 1 | Read byte valid |
| rd_byte | output | 8 | Read data byte |

## Verification
The bench builds the block with its default parameters: six channels, five control registers, 24-bit words and byte lanes. At that size the whole map is small enough to cover exhaustively. For each of the four wrap settings, a read stream is started from each of the eleven addresses. Thirteen registers are read in each stream, enough to pass at least one wrap point. The expected address sequence is computed from group base and size. Directed cases cover a sample arriving in mid-register and at a register boundary, abandoned partial writes, writes aimed at result addresses, and byte strobes that arrive during the wrong kind of access.

// File: rtl/afe_regbank_pkg.sv
package afe_regbank_pkg;

  // Pointer behaviour after a complete register, picked by the status wrap field
  typedef enum logic [1:0] {
    WRAP_HOLD  = 2'b00,
    WRAP_GROUP = 2'b01,
    WRAP_TYPE  = 2'b10,
    WRAP_ALL   = 2'b11
  } wrap_mode_e;

  // Kind of the access currently open
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_kind_e;

endpackage

// File: rtl/afe_addr_seq.sv
module afe_addr_seq
  import afe_regbank_pkg::*;
#(
  parameter int unsigned CH_COUNT   = 6,
  parameter int unsigned CTRL_COUNT = 5,
  parameter int unsigned CTRL_G0    = 3,
  parameter int unsigned NB         = 3,
  parameter int unsigned AW         = 4,
  parameter int unsigned BW         = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          step,
  input  logic [1:0]    mode,
  output logic [AW-1:0] ptr,
  output logic [BW-1:0] bidx,
  output logic          last,
  output logic          reg_done
);

  localparam int unsigned N_REGS = CH_COUNT + CTRL_COUNT;
  localparam logic [AW-1:0] ONE     = AW'(1);
  localparam logic [AW-1:0] LAST_A  = AW'(N_REGS - 1);
  localparam logic [AW-1:0] CH_A    = AW'(CH_COUNT);
  localparam logic [AW-1:0] CH_LAST = AW'(CH_COUNT - 1);
  localparam logic [AW-1:0] G1_A    = AW'(CH_COUNT + CTRL_G0);
  localparam logic [AW-1:0] G0_LAST = AW'(CH_COUNT + CTRL_G0 - 1);
  localparam logic [BW-1:0] B_LAST  = BW'(NB - 1);

  logic          is_data, in_g0;
  logic [AW-1:0] grp_nxt, typ_nxt, all_nxt, nxt_addr, clamp_addr;

  assign last     = (bidx == B_LAST);
  assign reg_done = step && last;

  // Three candidate successors in parallel, selected by the wrap field
  always_comb begin
    is_data = (ptr < CH_A);
    in_g0   = (ptr < G1_A);

    if (is_data)    grp_nxt = ptr[0] ? (ptr - ONE) : (ptr + ONE);
    else if (in_g0) grp_nxt = (ptr == G0_LAST) ? CH_A : (ptr + ONE);
    else            grp_nxt = (ptr == LAST_A)  ? G1_A : (ptr + ONE);

    if (is_data) typ_nxt = (ptr == CH_LAST) ? '0   : (ptr + ONE);
    else         typ_nxt = (ptr == LAST_A)  ? CH_A : (ptr + ONE);

    all_nxt = (ptr == LAST_A) ? '0 : (ptr + ONE);

    case (wrap_mode_e'(mode))
      WRAP_HOLD:  nxt_addr = ptr;
      WRAP_GROUP: nxt_addr = grp_nxt;
      WRAP_TYPE:  nxt_addr = typ_nxt;
      default:    nxt_addr = all_nxt;
    endcase
  end

  // Addresses past the map start at register zero
  assign clamp_addr = (start_addr > LAST_A) ? '0 : start_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      bidx <= '0;
    end else if (start) begin
      ptr  <= clamp_addr;
      bidx <= '0;
    end else if (step) begin
      bidx <= last ? '0 : (bidx + BW'(1));
      if (last) ptr <= nxt_addr;
    end
  end

endmodule

// File: rtl/afe_sample_hold.sv
module afe_sample_hold #(
  parameter int unsigned CH_COUNT = 6,
  parameter int unsigned REG_W    = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      smp_valid,
  input  logic [CH_COUNT*REG_W-1:0] smp_bus,
  input  logic                      load,
  output logic [CH_COUNT*REG_W-1:0] snap_bus
);

  localparam int unsigned BUS_W = CH_COUNT * REG_W;

  logic [BUS_W-1:0] live_q;

  // live_q always tracks the newest sample. snap_bus moves only when the
  // owner signals a register boundary, so a sample that lands in
  // mid-register stays held in live_q until then.
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= '0;
      snap_bus <= '0;
    end else begin
      if (smp_valid) live_q <= smp_bus;
      if (load)      snap_bus <= smp_valid ? smp_bus : live_q;
    end
  end

endmodule

// File: rtl/afe_ctrl_file.sv
module afe_ctrl_file #(
  parameter int unsigned CTRL_COUNT = 5,
  parameter int unsigned STAT_SLOT  = 3,
  parameter int unsigned REG_W      = 24,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned CS_W       = 3,
  parameter logic [1:0]  MODE_RST   = 2'b10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        byte_valid,
  input  logic [BYTE_W-1:0]           byte_in,
  input  logic                        commit,
  input  logic [CS_W-1:0]             sel,
  output logic [CTRL_COUNT*REG_W-1:0] ctrl_bus,
  output logic [1:0]                  mode
);

  localparam int unsigned ASM_W = REG_W - BYTE_W;

  logic [ASM_W-1:0] asm_q;
  logic [REG_W-1:0] word_in;

  // Earlier bytes of the word under assembly, most significant first
  always_ff @(posedge clk) begin
    if (rst)             asm_q <= '0;
    else if (byte_valid) asm_q <= {asm_q[ASM_W-BYTE_W-1:0], byte_in};
  end

  assign word_in = {asm_q, byte_in};

  for (genvar i = 0; i < CTRL_COUNT; i++) begin : g_reg
    localparam logic [REG_W-1:0] RST_VAL =
      (i == STAT_SLOT) ? {MODE_RST, {(REG_W-2){1'b0}}} : '0;
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                             q <= RST_VAL;
      else if (commit && sel == CS_W'(i))  q <= word_in;
    end
    assign ctrl_bus[i*REG_W +: REG_W] = q;
  end

  assign mode = ctrl_bus[STAT_SLOT*REG_W + REG_W - 1 -: 2];

endmodule

// File: rtl/afe_regbank.sv
module afe_regbank
  import afe_regbank_pkg::*;
#(
  parameter int unsigned CH_COUNT   = 6,
  parameter int unsigned CTRL_COUNT = 5,
  parameter int unsigned CTRL_G0    = 3,
  parameter int unsigned STAT_SLOT  = 3,
  parameter int unsigned REG_W      = 24,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter logic [1:0]  MODE_RST   = 2'b10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc_start,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic                      acc_wr,
  input  logic                      byte_req,
  input  logic                      wr_valid,
  input  logic [BYTE_W-1:0]         wr_byte,
  input  logic                      smp_ready,
  input  logic [CH_COUNT*REG_W-1:0] smp_data,
  output logic                      rd_valid,
  output logic [BYTE_W-1:0]         rd_byte
);

  localparam int unsigned N_REGS = CH_COUNT + CTRL_COUNT;
  localparam int unsigned NB     = REG_W / BYTE_W;
  localparam int unsigned BW     = (NB > 1) ? $clog2(NB) : 1;
  localparam int unsigned CS_W   = (CTRL_COUNT > 1) ? $clog2(CTRL_COUNT) : 1;
  localparam int unsigned SNAP_W = CH_COUNT * REG_W;
  localparam int unsigned CTRL_W = CTRL_COUNT * REG_W;
  localparam logic [ADDR_W-1:0] CH_A = ADDR_W'(CH_COUNT);

  acc_kind_e          kind_q;
  logic               rd_step, wr_step, step, last, reg_done, rd_load, wr_commit;
  logic [ADDR_W-1:0]  ptr, ctrl_off;
  logic [BW-1:0]      bidx;
  logic [1:0]         mode;
  logic [CS_W-1:0]    ctrl_sel;
  logic [SNAP_W-1:0]  snap_bus;
  logic [CTRL_W-1:0]  ctrl_bus;
  logic [REG_W-1:0]   words [N_REGS];
  logic [REG_W-1:0]   word_sel, word_sh;
  logic [BYTE_W-1:0]  byte_d;

  // Access kind; a start outranks any byte strobe in the same cycle
  always_ff @(posedge clk) begin
    if (rst)            kind_q <= ACC_IDLE;
    else if (acc_start) kind_q <= acc_wr ? ACC_WRITE : ACC_READ;
  end

  assign rd_step = byte_req && !acc_start && (kind_q == ACC_READ);
  assign wr_step = wr_valid && !acc_start && (kind_q == ACC_WRITE);
  assign step    = rd_step || wr_step;

  afe_addr_seq #(
    .CH_COUNT(CH_COUNT), .CTRL_COUNT(CTRL_COUNT), .CTRL_G0(CTRL_G0),
    .NB(NB), .AW(ADDR_W), .BW(BW)
  ) u_seq (
    .clk(clk), .rst(rst), .start(acc_start), .start_addr(acc_addr),
    .step(step), .mode(mode), .ptr(ptr), .bidx(bidx),
    .last(last), .reg_done(reg_done)
  );

  // Snapshot refresh: at a read start, or in a read whenever the pointer
  // sits on a register boundary (nothing of the register sent yet, or its
  // final byte going out this cycle)
  always_comb begin
    if (acc_start) rd_load = !acc_wr;
    else           rd_load = (kind_q == ACC_READ) &&
                             (((bidx == '0) && !rd_step) || (rd_step && last));
  end

  afe_sample_hold #(
    .CH_COUNT(CH_COUNT), .REG_W(REG_W)
  ) u_hold (
    .clk(clk), .rst(rst), .smp_valid(smp_ready), .smp_bus(smp_data),
    .load(rd_load), .snap_bus(snap_bus)
  );

  assign ctrl_off  = ptr - CH_A;
  assign ctrl_sel  = ctrl_off[CS_W-1:0];
  assign wr_commit = wr_step && last && (ptr >= CH_A);

  afe_ctrl_file #(
    .CTRL_COUNT(CTRL_COUNT), .STAT_SLOT(STAT_SLOT), .REG_W(REG_W),
    .BYTE_W(BYTE_W), .CS_W(CS_W), .MODE_RST(MODE_RST)
  ) u_ctrl (
    .clk(clk), .rst(rst), .byte_valid(wr_step), .byte_in(wr_byte),
    .commit(wr_commit), .sel(ctrl_sel), .ctrl_bus(ctrl_bus), .mode(mode)
  );

  // Flat read view of the map
  for (genvar g = 0; g < N_REGS; g++) begin : g_words
    if (g < CH_COUNT) begin : g_data
      assign words[g] = snap_bus[g*REG_W +: REG_W];
    end else begin : g_ctl
      assign words[g] = ctrl_bus[(g-CH_COUNT)*REG_W +: REG_W];
    end
  end

  always_comb begin
    word_sel = words[ptr];
    word_sh  = word_sel >> (BYTE_W * (NB - 1 - int'(bidx)));
    byte_d   = word_sh[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      rd_valid <= rd_step;
      if (rd_step) rd_byte <= byte_d;
    end
  end

endmodule

// File: rtl/afe_regbank_chk.sv
module afe_regbank_chk #(
  parameter int unsigned N_REGS = 11,
  parameter int unsigned NB     = 3,
  parameter int unsigned AW     = 4,
  parameter int unsigned BW     = 2,
  parameter int unsigned SNAP_W = 144,
  parameter int unsigned CTRL_W = 120
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_req,
  input logic              rd_valid,
  input logic              wr_valid,
  input logic              reg_done,
  input logic [1:0]        mode,
  input logic [AW-1:0]     ptr,
  input logic [BW-1:0]     bidx,
  input logic [SNAP_W-1:0] snap_bus,
  input logic [CTRL_W-1:0] ctrl_bus
);

  // R1
  rd_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(byte_req));

  // R1
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= AW'(N_REGS - 1));

  // R2
  bidx_range_chk: assert property (@(posedge clk) disable iff (rst)
    bidx <= BW'(NB - 1));

  // R4
  hold_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_done && mode == 2'b00) |-> $stable(ptr));

  // R9
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_valid) |-> $stable(ctrl_bus));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bidx) != '0 && bidx != '0) |-> $stable(snap_bus));

endmodule

bind afe_regbank afe_regbank_chk #(
  .N_REGS(N_REGS), .NB(NB), .AW(ADDR_W), .BW(BW),
  .SNAP_W(SNAP_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk(clk), .rst(rst), .byte_req(byte_req), .rd_valid(rd_valid),
  .wr_valid(wr_valid), .reg_done(reg_done), .mode(mode), .ptr(ptr),
  .bidx(bidx), .snap_bus(snap_bus), .ctrl_bus(ctrl_bus)
);

// File: tb/afe_regbank_test.sv
module afe_regbank_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CH = 6;
  localparam int CT = 5;
  localparam int RW = 24;

  logic            clk = 1'b0, rst = 1'b1;
  logic            acc_start = 1'b0, acc_wr = 1'b0, byte_req = 1'b0;
  logic            wr_valid = 1'b0, smp_ready = 1'b0;
  logic [3:0]      acc_addr = '0;
  logic [7:0]      wr_byte = '0;
  logic [CH*RW-1:0] smp_data = '0;
  logic [7:0]      rd_byte;
  logic            rd_valid;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [23:0] m_live [CH];
  logic [23:0] m_ctrl [CT];

  always #2.5 clk = ~clk;

  afe_regbank uut (
    .clk(clk), .rst(rst), .acc_start(acc_start), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .byte_req(byte_req), .wr_valid(wr_valid),
    .wr_byte(wr_byte), .smp_ready(smp_ready), .smp_data(smp_data),
    .rd_valid(rd_valid), .rd_byte(rd_byte)
  );

  function automatic logic [23:0] chan_val(int ch, int k);
    return 24'((k * 7 + ch + 1) * 32'h000F1E2D + k);
  endfunction

  // Successor address from group base and size (R4..R7)
  function automatic int nxt(int a, int m);
    int base, size;
    if (m == 0) return a;
    if (m == 1) begin
      if (a < 6)      begin base = a - (a % 2); size = 2; end
      else if (a < 9) begin base = 6; size = 3; end
      else            begin base = 9; size = 2; end
    end else if (m == 2) begin
      if (a < 6) begin base = 0; size = 6; end
      else       begin base = 6; size = 5; end
    end else begin
      base = 0; size = 11;
    end
    return base + ((a - base + 1) % size);
  endfunction

  function automatic logic [23:0] model(int a);
    return (a < 6) ? m_live[a] : m_ctrl[a-6];
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic start_acc(int a, bit w);
    @(negedge clk);
    acc_start = 1'b1; acc_addr = 4'(a); acc_wr = w;
    @(negedge clk);
    acc_start = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b, output logic v);
    @(negedge clk);
    byte_req = 1'b1;
    @(negedge clk);
    byte_req = 1'b0;
    b = rd_byte;
    v = rd_valid;
  endtask

  // Reads one register; checks value and that every byte was flagged valid (R1, R2)
  task automatic read_check(string req, logic [23:0] exp);
    logic [7:0] b0, b1, b2;
    logic v0, v1, v2;
    get_byte(b0, v0);
    get_byte(b1, v1);
    get_byte(b2, v2);
    check(req, {b0, b1, b2}, exp);
    check({req, " R1 rd_valid"}, {21'd0, v0, v1, v2}, 24'd7);
  endtask

  task automatic put_byte(logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1; wr_byte = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic write_word(logic [23:0] w);
    put_byte(w[23:16]);
    put_byte(w[15:8]);
    put_byte(w[7:0]);
  endtask

  task automatic pulse_sample(int k);
    @(negedge clk);
    for (int c = 0; c < CH; c++) begin
      smp_data[c*RW +: RW] = chan_val(c, k);
      m_live[c] = chan_val(c, k);
    end
    smp_ready = 1'b1;
    @(negedge clk);
    smp_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b0, b1, b2;
    logic        v;
    logic [23:0] old0;
    for (int c = 0; c < CH; c++) m_live[c] = '0;
    for (int i = 0; i < CT; i++) m_ctrl[i] = '0;
    m_ctrl[3] = 24'h800000;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R3: reset state of the outputs
    check("R3 rd_valid", {23'd0, rd_valid}, 24'd0);
    check("R3 rd_byte", {16'd0, rd_byte}, 24'd0);

    // R3, R6: control reset values, streamed under the reset wrap (type)
    start_acc(6, 1'b0);
    for (int r = 0; r < 6; r++) read_check("R3", model(6 + (r % 5)));

    // Load samples and program control registers
    pulse_sample(1);
    start_acc(6, 1'b1);
    for (int i = 0; i < 3; i++) begin
      m_ctrl[i] = 24'hC0FFEE ^ 24'(i * 32'h00131313);
      write_word(m_ctrl[i]);
    end
    start_acc(10, 1'b1);
    m_ctrl[4] = 24'h5EED42;
    write_word(m_ctrl[4]);

    // R4..R7 and R13: every wrap field value, every start address, past a wrap
    for (int m = 0; m < 4; m++) begin
      string tag;
      tag = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";
      start_acc(9, 1'b1);
      m_ctrl[3] = {2'(m), 22'h02C3A};
      write_word(m_ctrl[3]);   // R13: wrap field lives in bits [23:22] of 0x09
      for (int s = 0; s < 11; s++) begin
        int a;
        a = s;
        start_acc(s, 1'b0);
        for (int r = 0; r < 13; r++) begin
          read_check({tag, " R13"}, model(a));
          a = nxt(a, m);
        end
      end
    end
    // wrap field is now 2'b11 (whole map)

    // R8: write at a result address is dropped, pointer still advances to 0x06
    start_acc(5, 1'b1);
    write_word(24'hDEAD01);
    m_ctrl[0] = 24'h13579B;
    write_word(m_ctrl[0]);
    start_acc(5, 1'b0);
    read_check("R8", m_live[5]);
    read_check("R8", m_ctrl[0]);

    // R9: abandoned partial write leaves 0x07 untouched
    start_acc(7, 1'b1);
    put_byte(8'hAA);
    put_byte(8'hBB);
    start_acc(7, 1'b0);
    read_check("R9", m_ctrl[1]);

    // R12: byte request inside a write returns nothing
    start_acc(7, 1'b1);
    get_byte(b0, v);
    check("R12 byte_req in write", {23'd0, v}, 24'd0);
    m_ctrl[1] = 24'h2468AC;
    write_word(m_ctrl[1]);
    start_acc(7, 1'b0);
    read_check("R9", m_ctrl[1]);

    // R12: write byte inside a read alters neither stream nor register
    start_acc(6, 1'b0);
    get_byte(b0, v);
    put_byte(8'h77);
    get_byte(b1, v);
    get_byte(b2, v);
    check("R12 wr_valid in read", {b0, b1, b2}, m_ctrl[0]);
    read_check("R12", m_ctrl[1]);
    start_acc(6, 1'b0);
    read_check("R12", m_ctrl[0]);

    // R10: sample after first byte of 0x00 is deferred to the next register
    old0 = m_live[0];
    start_acc(0, 1'b0);
    get_byte(b0, v);
    pulse_sample(2);
    get_byte(b1, v);
    get_byte(b2, v);
    check("R10 old sample kept", {b0, b1, b2}, old0);
    read_check("R10 new sample next", m_live[1]);

    // R11: sample before any byte of the register is visible at once
    start_acc(3, 1'b0);
    pulse_sample(3);
    read_check("R11", m_live[3]);
    read_check("R11", m_live[4]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule